// File: doc/BRIEF.md
# Multi-Queue In-Order Micro-Op Merger

This block sits between three parallel decode clusters and the rename stage. Each cluster decodes whole fetch blocks and writes their micro-ops into its own private queue, up to three per cycle. Every block carries a sequence tag, and its last micro-op carries an end flag. Because the clusters work on different blocks at the same time, the blocks land in the three queues out of program order.

The merger puts program order back. It keeps an expected tag. It looks for the queue whose oldest entry carries that tag, and it drains that queue through a nine-lane output until the block's end flag has gone out. The expected tag then advances to the next value. While one queue is being drained, the other two keep accepting writes. A downstream ready input stalls the output without losing any micro-ops. A per-queue full flag pushes back on each decoder. A flush input empties every queue and loads the expected tag, so that decoding can restart on the corrected path.

Top module: `uop_merge_top`

## Requirements
- R1: After reset, out_count is 0 and every q_full bit is 0. The expected tag is 0.
- R2: Each queue accepts 0 to 3 micro-ops per cycle. The count is wr_cnt, and wr_data lane i of that queue is written first. Micro-ops of the expected block appear on the output in the cycle after they are written.
- R3: The output carries up to 9 micro-ops per cycle, all from one queue. They fill lanes 0 upward in the order they were written, and out_count gives the number of valid lanes.
- R4: Blocks leave in ascending tag order, modulo 2^SEQ_W. The expected tag, shown on out_seq, moves up by one once the end-flagged micro-op has been accepted with out_ready high.
- R5: In any cycle, no lane after an end-flagged lane is valid. Two blocks held back-to-back in one queue therefore leave in separate cycles.
- R6: If no queue holds the expected tag at its head, out_count is 0, even when other queues hold data.
- R7: A queue that is not being drained keeps accepting writes, so all blocks arrive intact while the output is busy.
- R8: While out_ready is low, nothing is removed. The same micro-ops stay on the same lanes in the next cycle, and out_count does not drop.
- R9: The q_full bit of a queue is high exactly when it has fewer than 3 free entries (WR_W), out of a DEPTH of 16.
- R10: A flush empties all queues and loads the expected tag from flush_seq. Writes in the flush cycle are dropped. Three micro-ops written in the cycle after the flush all appear on the output together in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cnt | input | NQ*2 | Per queue, the number of micro-ops written this cycle (0..3) |
| wr_data | input | NQ*WR_W*UOP_W | Per queue, the micro-op payload lanes |
| wr_end | input | NQ*WR_W | Per queue lane, set on the last micro-op of a block |
| wr_seq | input | NQ*SEQ_W | Per queue, the tag of the block being written this cycle |
| q_full | output | NQ | Per queue backpressure to its decoder |
| flush | input | 1 | Mispredict flush of all queues |
| flush_seq | input | SEQ_W | Expected tag loaded by a flush |
| out_ready | input | 1 | Downstream accepts the output this cycle |
| out_count | output | 4 | Number of valid output lanes (0..9) |
| out_data | output | RD_W*UOP_W | Output micro-op lanes |
| out_end | output | RD_W | End flag per output lane |
| out_seq | output | SEQ_W | Tag of the block now on the output (the expected tag) |

## Verification
A table of ten blocks with lengths from 1 to 12 is spread unevenly over the three queues. It is streamed through twice. The first pass keeps ready high and starts near the tag wrap point, which separates correct tag ordering and wrap from plain queue-by-queue draining. The second pass drops ready every third cycle, which exposes any lost or duplicated micro-ops under stalls. Directed cases pin down the individual rules:
- a 12-op block buffered under a stall, which must leave as 9 and then 3;
- blocks written ahead of their turn, which must wait;
- two blocks stacked in one queue, which must not share a cycle;
- the full threshold at 12 and 15 entries;
- a flush that drops same-cycle writes and then passes three fresh micro-ops in one cycle.

// File: rtl/uopq_pkg.sv
package uopq_pkg;
   localparam int unsigned QUEUES_DEF = 3;
   localparam int unsigned UOP_W_DEF  = 16;
   localparam int unsigned SEQ_W_DEF  = 4;
   localparam int unsigned DEPTH_DEF  = 16;
   localparam int unsigned WR_W_DEF   = 3;
   localparam int unsigned RD_W_DEF   = 9;

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      return $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/uopq_fifo.sv
module uopq_fifo #(
   parameter int unsigned UOP_W = 16,
   parameter int unsigned SEQ_W = 4,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned WR_W  = 3,
   parameter int unsigned RD_W  = 9
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                flush,
   input  logic [$clog2(WR_W+1)-1:0]           wr_cnt,
   input  logic [WR_W*UOP_W-1:0]               wr_data,
   input  logic [WR_W-1:0]                     wr_end,
   input  logic [SEQ_W-1:0]                    wr_seq,
   input  logic [$clog2(RD_W+1)-1:0]           pop_cnt,
   output logic                                full,
   output logic [$clog2(DEPTH+1)-1:0]          level,
   output logic [RD_W*UOP_W-1:0]               head_data,
   output logic [RD_W-1:0]                     head_end,
   output logic [SEQ_W-1:0]                    head_seq
);
   localparam int unsigned PW     = $clog2(DEPTH);
   localparam int unsigned CNT_W  = $clog2(DEPTH+1);
   localparam int unsigned WCW    = $clog2(WR_W+1);
   localparam int unsigned FULL_AT = DEPTH - WR_W;

   logic [UOP_W-1:0] data_mem [DEPTH];
   logic             end_mem  [DEPTH];
   logic [SEQ_W-1:0] seq_mem  [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr;
   logic [CNT_W-1:0] level_q;

   // storage writes: dropped during a flush
   always_ff @(posedge clk) begin
      if (!flush) begin
         for (int i = 0; i < WR_W; i++) begin
            if (WCW'(i) < wr_cnt) begin
               data_mem[wr_ptr + PW'(i)] <= wr_data[i*UOP_W +: UOP_W];
               end_mem[wr_ptr + PW'(i)]  <= wr_end[i];
               seq_mem[wr_ptr + PW'(i)]  <= wr_seq;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
      end else if (flush) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
      end else begin
         wr_ptr  <= wr_ptr + PW'(wr_cnt);
         rd_ptr  <= rd_ptr + PW'(pop_cnt);
         level_q <= level_q + CNT_W'(wr_cnt) - CNT_W'(pop_cnt);
      end
   end

   generate
      for (genvar l = 0; l < RD_W; l++) begin : g_lane
         assign head_data[l*UOP_W +: UOP_W] = data_mem[rd_ptr + PW'(l)];
         assign head_end[l]                 = end_mem[rd_ptr + PW'(l)];
      end
   endgenerate

   assign head_seq = seq_mem[rd_ptr];
   assign level    = level_q;
   assign full     = (level_q > CNT_W'(FULL_AT));

   // decoder obeys the full flag, so no write is lost (R9)
   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !flush) |-> (wr_cnt == '0));
   // merger never removes more than is stored (R3)
   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      CNT_W'(pop_cnt) <= level_q);
   // flush leaves the queue empty (R10)
   assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0));
endmodule

// File: rtl/uopq_pick.sv
module uopq_pick #(
   parameter int unsigned NQ    = 3,
   parameter int unsigned UOP_W = 16,
   parameter int unsigned SEQ_W = 4,
   parameter int unsigned CNT_W = 5,
   parameter int unsigned RD_W  = 9
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NQ*CNT_W-1:0]              q_level,
   input  logic [NQ*SEQ_W-1:0]              q_head_seq,
   input  logic [NQ*RD_W*UOP_W-1:0]         q_head_data,
   input  logic [NQ*RD_W-1:0]               q_head_end,
   input  logic [SEQ_W-1:0]                 exp_seq,
   input  logic                             out_ready,
   output logic [NQ*$clog2(RD_W+1)-1:0]     pop_cnt,
   output logic [$clog2(RD_W+1)-1:0]        out_count,
   output logic [RD_W*UOP_W-1:0]            out_data,
   output logic [RD_W-1:0]                  out_end,
   output logic                             blk_done
);
   localparam int unsigned RCW = $clog2(RD_W+1);

   logic [NQ-1:0]         hit;
   logic [NQ-1:0]         sel_oh;
   logic                  any_hit;
   logic [CNT_W-1:0]      win_level;
   logic [RD_W*UOP_W-1:0] win_data;
   logic [RD_W-1:0]       win_end;
   logic                  end_seen;
   logic [RCW-1:0]        n_out;

   generate
      for (genvar q = 0; q < NQ; q++) begin : g_hit
         assign hit[q] = (q_level[q*CNT_W +: CNT_W] != '0) &&
                         (q_head_seq[q*SEQ_W +: SEQ_W] == exp_seq);
         assign pop_cnt[q*RCW +: RCW] = (out_ready && sel_oh[q]) ? n_out : '0;
      end
   endgenerate

   // pick the queue whose head carries the expected tag
   always_comb begin
      any_hit   = 1'b0;
      sel_oh    = '0;
      win_level = '0;
      win_data  = '0;
      win_end   = '0;
      for (int q = 0; q < NQ; q++) begin
         if (hit[q] && !any_hit) begin
            any_hit   = 1'b1;
            sel_oh[q] = 1'b1;
            win_level = q_level[q*CNT_W +: CNT_W];
            win_data  = q_head_data[q*RD_W*UOP_W +: RD_W*UOP_W];
            win_end   = q_head_end[q*RD_W +: RD_W];
         end
      end
   end

   // fill lanes from 0 up, stopping after the block end
   always_comb begin
      end_seen = 1'b0;
      n_out    = '0;
      out_data = '0;
      out_end  = '0;
      for (int l = 0; l < RD_W; l++) begin
         if (any_hit && !end_seen && (CNT_W'(l) < win_level)) begin
            out_data[l*UOP_W +: UOP_W] = win_data[l*UOP_W +: UOP_W];
            out_end[l] = win_end[l];
            n_out      = n_out + RCW'(1);
            if (win_end[l]) end_seen = 1'b1;
         end
      end
   end

   assign out_count = n_out;
   assign blk_done  = end_seen && out_ready;

   // at most one queue head may carry the expected tag (R4)
   assert_one_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
endmodule

// File: rtl/uop_merge_top.sv
module uop_merge_top #(
   parameter int unsigned NQ    = uopq_pkg::QUEUES_DEF,
   parameter int unsigned UOP_W = uopq_pkg::UOP_W_DEF,
   parameter int unsigned SEQ_W = uopq_pkg::SEQ_W_DEF,
   parameter int unsigned DEPTH = uopq_pkg::DEPTH_DEF,
   parameter int unsigned WR_W  = uopq_pkg::WR_W_DEF,
   parameter int unsigned RD_W  = uopq_pkg::RD_W_DEF
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NQ*$clog2(WR_W+1)-1:0]      wr_cnt,
   input  logic [NQ*WR_W*UOP_W-1:0]          wr_data,
   input  logic [NQ*WR_W-1:0]                wr_end,
   input  logic [NQ*SEQ_W-1:0]               wr_seq,
   output logic [NQ-1:0]                     q_full,
   input  logic                              flush,
   input  logic [SEQ_W-1:0]                  flush_seq,
   input  logic                              out_ready,
   output logic [$clog2(RD_W+1)-1:0]         out_count,
   output logic [RD_W*UOP_W-1:0]             out_data,
   output logic [RD_W-1:0]                   out_end,
   output logic [SEQ_W-1:0]                  out_seq
);
   localparam int unsigned WCW   = uopq_pkg::cnt_bits(WR_W);
   localparam int unsigned RCW   = uopq_pkg::cnt_bits(RD_W);
   localparam int unsigned CNT_W = uopq_pkg::cnt_bits(DEPTH);

   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_chk_pow2
         $error("DEPTH must be a power of two");
      end
      if (DEPTH < RD_W) begin : g_chk_depth
         $error("DEPTH must hold a full output row");
      end
      if (RD_W < WR_W) begin : g_chk_width
         $error("read width must not be below write width");
      end
      if (NQ < 2) begin : g_chk_nq
         $error("at least two queues are needed");
      end
   endgenerate

   logic [NQ*CNT_W-1:0]      lvl_all;
   logic [NQ*SEQ_W-1:0]      hseq_all;
   logic [NQ*RD_W*UOP_W-1:0] hdata_all;
   logic [NQ*RD_W-1:0]       hend_all;
   logic [NQ*RCW-1:0]        pop_all;
   logic [SEQ_W-1:0]         exp_seq;
   logic                     blk_done;

   generate
      for (genvar q = 0; q < NQ; q++) begin : g_q
         uopq_fifo #(
            .UOP_W(UOP_W), .SEQ_W(SEQ_W), .DEPTH(DEPTH),
            .WR_W(WR_W), .RD_W(RD_W)
         ) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush),
            .wr_cnt    (wr_cnt[q*WCW +: WCW]),
            .wr_data   (wr_data[q*WR_W*UOP_W +: WR_W*UOP_W]),
            .wr_end    (wr_end[q*WR_W +: WR_W]),
            .wr_seq    (wr_seq[q*SEQ_W +: SEQ_W]),
            .pop_cnt   (pop_all[q*RCW +: RCW]),
            .full      (q_full[q]),
            .level     (lvl_all[q*CNT_W +: CNT_W]),
            .head_data (hdata_all[q*RD_W*UOP_W +: RD_W*UOP_W]),
            .head_end  (hend_all[q*RD_W +: RD_W]),
            .head_seq  (hseq_all[q*SEQ_W +: SEQ_W])
         );
      end
   endgenerate

   uopq_pick #(
      .NQ(NQ), .UOP_W(UOP_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .RD_W(RD_W)
   ) u_pick (
      .clk         (clk),
      .rst_n       (rst_n),
      .q_level     (lvl_all),
      .q_head_seq  (hseq_all),
      .q_head_data (hdata_all),
      .q_head_end  (hend_all),
      .exp_seq     (exp_seq),
      .out_ready   (out_ready),
      .pop_cnt     (pop_all),
      .out_count   (out_count),
      .out_data    (out_data),
      .out_end     (out_end),
      .blk_done    (blk_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        exp_seq <= '0;
      else if (flush)    exp_seq <= flush_seq;
      else if (blk_done) exp_seq <= exp_seq + SEQ_W'(1);
   end

   assign out_seq = exp_seq;

   // stalled output is held, nothing lost (R8)
   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_ready && !flush && out_count != '0) |=>
      ((out_count >= $past(out_count)) &&
       (out_data[UOP_W-1:0] == $past(out_data[UOP_W-1:0]))));
   // unfinished block keeps its tag on the output (R4)
   assert_tag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ready && !flush && out_count != '0 && out_end == '0) |=>
      (out_seq == $past(out_seq)));
   // output empty right after a flush (R10)
   assert_flush_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (out_count == '0));
endmodule

// File: tb/uop_merge_top_test.sv
`timescale 1ns/1ps
module uop_merge_top_test;
   localparam int NQ = 3, UW = 16, SW = 4, WR = 3, RD = 9;
   localparam int NBLK = 10;
   localparam int TBL_Q   [NBLK] = '{0, 1, 2, 0, 1, 2, 2, 0, 1, 0};
   localparam int TBL_LEN [NBLK] = '{5, 2, 9, 1, 12, 3, 4, 7, 1, 3};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NQ*2-1:0]     wr_cnt = '0;
   logic [NQ*WR*UW-1:0] wr_data = '0;
   logic [NQ*WR-1:0]    wr_end = '0;
   logic [NQ*SW-1:0]    wr_seq = '0;
   logic [NQ-1:0]       q_full;
   logic                flush = 1'b0;
   logic [SW-1:0]       flush_seq = '0;
   logic                out_ready = 1'b0;
   logic [3:0]          out_count;
   logic [RD*UW-1:0]    out_data;
   logic [RD-1:0]       out_end;
   logic [SW-1:0]       out_seq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   uop_merge_top uut (
      .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_data(wr_data),
      .wr_end(wr_end), .wr_seq(wr_seq), .q_full(q_full), .flush(flush),
      .flush_seq(flush_seq), .out_ready(out_ready), .out_count(out_count),
      .out_data(out_data), .out_end(out_end), .out_seq(out_seq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic clear_wr();
      wr_cnt = '0; wr_data = '0; wr_end = '0; wr_seq = '0;
   endtask

   task automatic put(input int q, input int seq, input int n, input int blk,
                      input int idx0, input bit last);
      wr_cnt[q*2 +: 2]   = 2'(n);
      wr_seq[q*SW +: SW] = SW'(seq);
      for (int i = 0; i < WR; i++) begin
         wr_data[(q*WR+i)*UW +: UW] = (i < n) ? {8'(blk), 8'(idx0 + i)} : 16'h0;
         wr_end[q*WR+i] = last && (i == n - 1);
      end
   endtask

   function automatic int lane(input int l);
      return int'(out_data[l*UW +: UW]);
   endfunction

   task automatic run_pass(input int base, input bit stall);
      int qnext [NQ];
      int qoff  [NQ];
      int mb, mi, cyc;
      flush = 1'b1; flush_seq = SW'(base);
      tick();
      flush = 1'b0;
      for (int q = 0; q < NQ; q++) begin
         qoff[q] = 0; qnext[q] = NBLK;
         for (int b = NBLK - 1; b >= 0; b--) if (TBL_Q[b] == q) qnext[q] = b;
      end
      mb = 0; mi = 0; cyc = 0;
      while (mb < NBLK && cyc < 3000) begin
         clear_wr();
         out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
         for (int q = 0; q < NQ; q++) begin
            if (qnext[q] < NBLK && !q_full[q]) begin
               int n;
               int b;
               b = qnext[q];
               n = TBL_LEN[b] - qoff[q];
               if (n > WR) n = WR;
               put(q, (base + b) % 16, n, b, qoff[q], (qoff[q] + n) == TBL_LEN[b]);
               qoff[q] += n;
               if (qoff[q] == TBL_LEN[b]) begin
                  qoff[q] = 0;
                  qnext[q] = NBLK;
                  for (int k = NBLK - 1; k > b; k--) if (TBL_Q[k] == q) qnext[q] = k;
               end
            end
         end
         if (out_ready) begin
            for (int l = 0; l < int'(out_count); l++) begin
               if (mb < NBLK) begin
                  chk(lane(l) == ((mb << 8) | mi), "R4 R7 order", lane(l), (mb << 8) | mi);
                  chk(out_end[l] == (mi == TBL_LEN[mb] - 1), "R5 end flag",
                      int'(out_end[l]), int'(mi == TBL_LEN[mb] - 1));
                  chk(int'(out_seq) == (base + mb) % 16, "R4 tag", int'(out_seq), (base + mb) % 16);
                  if (mi == TBL_LEN[mb] - 1) begin mi = 0; mb++; end
                  else mi++;
               end
            end
         end
         tick();
         cyc++;
      end
      clear_wr();
      chk(mb == NBLK, "R7 all blocks", mb, NBLK);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(out_count == 0, "R1 count", out_count, 0);
      chk(q_full == 0, "R1 full", q_full, 0);
      rst_n = 1'b1;
      tick();
      chk(out_seq == 0, "R1 tag", out_seq, 0);

      // R2, R8, R3: 12-op block under stall, then drained as 9 + 3
      out_ready = 1'b0;
      put(0, 0, 3, 0, 0, 0);
      tick(); clear_wr();
      chk(out_count == 3, "R2 latency", out_count, 3);
      chk(lane(0) == 16'h0000, "R2 lane0", lane(0), 0);
      tick();
      chk(out_count == 3, "R8 held count", out_count, 3);
      chk(lane(2) == 16'h0002, "R8 held lane2", lane(2), 2);
      put(0, 0, 3, 0, 3, 0); tick();
      put(0, 0, 3, 0, 6, 0); tick();
      put(0, 0, 3, 0, 9, 1); tick();
      clear_wr();
      out_ready = 1'b1;
      chk(out_count == 9, "R3 nine wide", out_count, 9);
      chk(lane(8) == 16'h0008, "R3 lane8", lane(8), 8);
      tick();
      chk(out_count == 3, "R3 remainder", out_count, 3);
      chk(lane(0) == 16'h0009, "R3 lane0", lane(0), 9);
      chk(out_end == 9'b000000100, "R5 end lane", out_end, 4);
      tick();
      chk(out_count == 0 && out_seq == 1, "R4 advance", out_seq, 1);

      // R6: later blocks wait for the expected one
      put(1, 2, 3, 2, 0, 1);
      put(2, 3, 2, 3, 0, 1);
      tick(); clear_wr();
      chk(out_count == 0, "R6 wait", out_count, 0);
      put(0, 1, 2, 1, 0, 1);
      tick(); clear_wr();
      chk(out_count == 2 && lane(0) == 16'h0100, "R6 expected first", lane(0), 16'h0100);
      tick();
      chk(out_count == 3 && lane(0) == 16'h0200, "R4 tag two", lane(0), 16'h0200);
      tick();
      chk(out_count == 2 && lane(0) == 16'h0300, "R4 tag three", lane(0), 16'h0300);
      tick();
      chk(out_seq == 4, "R4 tag four", out_seq, 4);

      // R5: two blocks stacked in one queue
      out_ready = 1'b0;
      put(0, 4, 2, 4, 0, 1); tick();
      put(0, 5, 2, 5, 0, 1); tick();
      clear_wr();
      out_ready = 1'b1;
      chk(out_count == 2 && out_end == 9'b10, "R5 split first", out_count, 2);
      tick();
      chk(out_count == 2 && lane(0) == 16'h0500, "R5 split second", lane(0), 16'h0500);
      tick();

      // R9: full threshold, R6 with a foreign tag
      for (int k = 0; k < 4; k++) begin
         put(2, 9, 3, 9, 3 * k, 0); tick();
      end
      clear_wr();
      chk(q_full == 3'b000, "R9 twelve entries", q_full, 0);
      chk(out_count == 0, "R6 foreign tag", out_count, 0);
      put(2, 9, 3, 9, 12, 1); tick(); clear_wr();
      chk(q_full == 3'b100, "R9 fifteen entries", q_full, 4);

      // R10: flush drops same-cycle writes, then 3 ops pass in one cycle
      flush = 1'b1; flush_seq = 4'd12;
      put(0, 12, 3, 12, 0, 0);
      tick();
      flush = 1'b0; clear_wr();
      chk(out_count == 0 && q_full == 0, "R10 emptied", out_count, 0);
      chk(out_seq == 12, "R10 tag load", out_seq, 12);
      put(0, 12, 3, 12, 16, 1);
      tick(); clear_wr();
      chk(out_count == 3 && lane(0) == 16'h0c10, "R10 restart", lane(0), 16'h0c10);
      tick();

      // table walks: tag wrap without stalls, then with stalls (R7, R8)
      run_pass(14, 1'b0);
      run_pass(3, 1'b1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule